// File: doc/BRIEF.md
# Cascaded Serial-Bus Clock Divider

This block derives a slow serial-bus clock, such as the clock for a display data channel, from a fast parent clock. It does this with a cascade of four counters, all in the parent clock domain. A fixed prescaler comes first. A mandatory divide-by-ten stage follows it. Then comes a power-of-two stage chosen by a 3-bit exponent field, and last a linear stage that divides by a 4-bit multiplier field plus a fixed offset. Each stage produces a clock-enable for the stage after it. The last stage shapes the output clock.

The prescale value and the multiplier offset are build parameters. The exponent and multiplier arrive on a 7-bit control word. The block samples that word in the first cycle after reset, and after that only at the end of each output period. A change made in the middle of a period therefore never shortens or stretches the current output pulse. Each rising edge of the output comes with a one-cycle tick strobe, which logic in the parent domain can use in place of the divided clock.

Top module: `busclk_div`

## Requirements
- R1: While reset is asserted, `bus_clk` and `edge_tick` are both low.
- R2: In steady state, the output period in parent cycles is PRESCALE × 10 × 2^N × D. Here N = `ctrl_word[2:0]` and D is the effective divisor of the last stage.
- R3: The divide-by-ten stage is always present. With PRESCALE = 1, N = 0 and D = 1, the period is exactly 10 parent cycles.
- R4: Each increment of N (`ctrl_word[2:0]`, 0 to 7) doubles the output period.
- R5: The last stage divides by D = M + M_OFFSET, where M = `ctrl_word[6:3]` (0 to 15).
- R6: When M + M_OFFSET is zero, D is taken as 1, and the output keeps running.
- R7: A new control word takes effect only at the end of an output period. The period running when the word changes completes with the old setting.
- R8: `bus_clk` is high for exactly half of every period. That is PRESCALE × 5 × 2^N × D cycles.
- R9: `edge_tick` is high for exactly the one cycle in which `bus_clk` rises, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast parent clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctrl_word | input | 7 | Divider setting: M in [6:3], N in [2:0] |
| bus_clk | output | 1 | Divided serial-bus clock |
| edge_tick | output | 1 | One-cycle strobe at each rising edge of `bus_clk` |

## Verification
`bus_clk` and `edge_tick` are both registered, and they change on the same clock edge, when the last stage wraps. The bench samples both on the falling edge, so the tick cycle is the first sample in which the clock is high. Because a control word is only adopted at a wrap, the period that follows a change still has the old length. The bench therefore checks that period against the old setting and the period after it against the new one, and it measures the high time over the same window. Two instances cover the default build and a build with unit prescale and zero offset. Together they sweep every multiplier value and every exponent value.

// File: rtl/busclk_div_pkg.sv
package busclk_div_pkg;

  localparam int unsigned CTRL_N_W = 3;
  localparam int unsigned CTRL_M_W = 4;
  localparam int unsigned CTRL_W   = CTRL_N_W + CTRL_M_W;
  localparam int unsigned DEC_LIM  = 9;
  localparam int unsigned DEC_HALF = 4;

  // Multiplier field sits above the exponent field
  typedef struct packed {
    logic [CTRL_M_W-1:0] mult;
    logic [CTRL_N_W-1:0] expo;
  } busclk_ctrl_t;

  function automatic int unsigned eff_divisor(int unsigned m, int unsigned off);
    int unsigned s;
    s = m + off;
    return (s == 0) ? 1 : s;
  endfunction

endpackage

// File: rtl/busclk_div_stage.sv
module busclk_div_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt,
  output logic         term
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    term  = step && (cnt_q == lim);
    cnt_d = cnt_q;
    if (term)
      cnt_d = '0;
    else if (step)
      cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim); // R5

endmodule

// File: rtl/busclk_div_phase.sv
module busclk_div_phase #(
  parameter int unsigned NW = 7,
  parameter int unsigned DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_p,
  input  logic          wrap,
  input  logic [3:0]    d_cnt,
  input  logic [NW-1:0] n_cnt,
  input  logic [NW-1:0] n_lim,
  input  logic [NW-1:0] n_half,
  input  logic          n_zero,
  input  logic [DW-1:0] m_cnt,
  input  logic [DW-1:0] act_d,
  output logic          bus_clk,
  output logic          edge_tick
);

  logic          out_q, out_d;
  logic          tick_q, tick_d;
  logic          fall_hit;
  logic [DW-1:0] d_half;

  always_comb begin
    d_half = act_d >> 1;
    if (!act_d[0])
      fall_hit = (m_cnt == d_half - DW'(1)) && (n_cnt == n_lim) && (d_cnt == 4'd9);
    else if (!n_zero)
      fall_hit = (m_cnt == d_half) && (n_cnt == n_half) && (d_cnt == 4'd9);
    else
      fall_hit = (m_cnt == d_half) && (d_cnt == 4'd4);
  end

  always_comb begin
    tick_d = wrap;
    out_d  = out_q;
    if (wrap)
      out_d = 1'b1;
    else if (en_p && fall_hit)
      out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      out_q  <= out_d;
      tick_q <= tick_d;
    end
  end

  assign bus_clk   = out_q;
  assign edge_tick = tick_q;

  AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_tick |-> $rose(bus_clk)); // R9
  AST_RISE_HAS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_clk) |-> edge_tick); // R9
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_tick |=> !edge_tick); // R9

endmodule

// File: rtl/busclk_div.sv
module busclk_div
  import busclk_div_pkg::*;
#(
  parameter int unsigned PRESCALE = 2,
  parameter int unsigned M_OFFSET = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] ctrl_word,
  output logic       bus_clk,
  output logic       edge_tick
);

  localparam int unsigned PW   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int unsigned NW   = (1 << CTRL_N_W) - 1;
  localparam int unsigned DMAX = (1 << CTRL_M_W) - 1 + M_OFFSET;
  localparam int unsigned DW   = $clog2(DMAX + 1);

  busclk_ctrl_t        ctrl;
  logic                primed_q, primed_d;
  logic [CTRL_N_W-1:0] act_n_q, act_n_d;
  logic [DW-1:0]       act_d_q, act_d_d;
  logic                load;
  logic                en_p, dec_term, n_term, wrap;
  logic [3:0]          d_cnt;
  logic [NW-1:0]       n_cnt, n_lim, n_half;
  logic [DW-1:0]       m_cnt;

  assign ctrl = busclk_ctrl_t'(ctrl_word);

  // Active setting: sampled once after reset, then only at a wrap
  always_comb begin
    load     = !primed_q || wrap;
    primed_d = 1'b1;
    act_n_d  = act_n_q;
    act_d_d  = act_d_q;
    if (load) begin
      act_n_d = ctrl.expo;
      act_d_d = DW'(eff_divisor(int'(ctrl.mult), M_OFFSET));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      act_n_q  <= '0;
      act_d_q  <= DW'(1);
    end else begin
      primed_q <= primed_d;
      act_n_q  <= act_n_d;
      act_d_q  <= act_d_d;
    end
  end

  always_comb begin
    n_lim  = (NW'(1) << act_n_q) - NW'(1);
    n_half = (act_n_q == '0) ? '0 : (NW'(1) << (act_n_q - CTRL_N_W'(1))) - NW'(1);
  end

  // Prescale stage: bypassed entirely for a unit prescale
  generate
    if (PRESCALE == 1) begin : g_no_pre
      assign en_p = primed_q;
    end else begin : g_pre
      logic [PW-1:0] p_cnt;
      busclk_div_stage #(.W(PW)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (primed_q),
        .lim   (PW'(PRESCALE - 1)),
        .cnt   (p_cnt),
        .term  (en_p)
      );
    end
  endgenerate

  busclk_div_stage #(.W(4)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (en_p),
    .lim   (4'(DEC_LIM)),
    .cnt   (d_cnt),
    .term  (dec_term)
  );

  busclk_div_stage #(.W(NW)) u_pow (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (dec_term),
    .lim   (n_lim),
    .cnt   (n_cnt),
    .term  (n_term)
  );

  busclk_div_stage #(.W(DW)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (n_term),
    .lim   (act_d_q - DW'(1)),
    .cnt   (m_cnt),
    .term  (wrap)
  );

  busclk_div_phase #(.NW(NW), .DW(DW)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_p      (en_p),
    .wrap      (wrap),
    .d_cnt     (d_cnt),
    .n_cnt     (n_cnt),
    .n_lim     (n_lim),
    .n_half    (n_half),
    .n_zero    (act_n_q == '0),
    .m_cnt     (m_cnt),
    .act_d     (act_d_q),
    .bus_clk   (bus_clk),
    .edge_tick (edge_tick)
  );

  AST_SETTING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_n_q) && $stable(act_d_q))); // R7
  AST_DIVISOR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    act_d_q != '0); // R6
  AST_DEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    d_cnt <= 4'd9); // R3
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |-> !bus_clk); // R1

endmodule

// File: tb/busclk_div_bench.sv
module busclk_div_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] ctrl0, ctrl1;
  logic       out0, tick0, out1, tick1;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busclk_div #(.PRESCALE(2), .M_OFFSET(1)) u_busclk_div (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl0), .bus_clk(out0), .edge_tick(tick0)
  );

  busclk_div #(.PRESCALE(1), .M_OFFSET(0)) u_busclk_div_z (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl1), .bus_clk(out1), .edge_tick(tick1)
  );

  function automatic int exp_len(int sel, logic [6:0] c);
    int p, off, d;
    p   = (sel == 1) ? 1 : 2;
    off = (sel == 1) ? 0 : 1;
    d   = int'(c[6:3]) + off;
    if (d == 0) d = 1;
    return p * 10 * (1 << c[2:0]) * d;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Advance to the next tick; count samples and high samples on the way
  task automatic next_tick(int sel, output int len, output int hi);
    logic o, t, prev_o, prev_t;
    len = 0; hi = 0;
    prev_o = (sel == 1) ? out1 : out0;
    prev_t = 1'b0;
    do begin
      @(negedge clk);
      o = (sel == 1) ? out1 : out0;
      t = (sel == 1) ? tick1 : tick0;
      len++;
      if (o) hi++;
      if (t && prev_t) check("R9 tick width", 2, 1);
      if (t) check("R9 tick on rising edge", int'({prev_o, o}), 1);
      prev_o = o;
      prev_t = t;
    end while (!t);
  endtask

  task automatic apply(int sel, logic [6:0] nc, string tag);
    int l, h;
    logic [6:0] oldc;
    oldc = (sel == 1) ? ctrl1 : ctrl0;
    next_tick(sel, l, h);
    if (sel == 1) ctrl1 = nc; else ctrl0 = nc;
    next_tick(sel, l, h);
    check("R7 old period kept", l, exp_len(sel, oldc));
    next_tick(sel, l, h);
    check(tag, l, exp_len(sel, nc));
    check("R8 half high", h, exp_len(sel, nc) / 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ctrl0 = 7'd0;
    ctrl1 = 7'd0;
    repeat (4) @(negedge clk);
    check("R1 out0 in reset", int'(out0), 0);
    check("R1 tick0 in reset", int'(tick0), 0);
    check("R1 out1 in reset", int'(out1), 0);
    check("R1 tick1 in reset", int'(tick1), 0);
    rst_n = 1'b1;

    // Unit prescale, zero offset instance
    apply(1, {4'd0, 3'd0}, "R3 decade only");
    apply(1, {4'd1, 3'd0}, "R6 M=1 matches M=0");
    apply(1, {4'd0, 3'd0}, "R6 zero divisor as one");
    apply(1, {4'd2, 3'd1}, "R4 N=1 M=2");
    apply(1, {4'd3, 3'd0}, "R5 M=3 no offset");

    // Default instance: full multiplier sweep, then full exponent sweep
    for (int m = 0; m < 16; m++)
      apply(0, {4'(m), 3'd0}, "R5 multiplier sweep");
    for (int n = 0; n < 8; n++)
      apply(0, {4'd1, 3'(n)}, "R4 exponent sweep");
    apply(0, {4'd4, 3'd2}, "R2 combined setting");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule